// File: doc/BRIEF.md
# Audio Transmit FIFO with DMA Request and Panic Levels

This block buffers 32-bit audio samples between a system-clock write port and a serializer that runs on a slower, unrelated audio bit clock. Samples arrive from a register or DMA bus on the system side and are stored in a 64-entry dual-clock FIFO. The read side presents the oldest sample without being asked and advances when the serializer pops. If the serializer pops from an empty FIFO, it receives zero for that slot and a sticky error is raised.

On the system side the block reports whether the FIFO is full, empty or able to take a sample, and raises a "needs writing" flag whose trigger point software selects. Two 7-bit levels, each set on its own, drive a DMA request and a panic output, and both are gated by a DMA enable. A control write starts a round trip through the audio clock domain. A status flag reports when that round trip has finished, so software knows that a clear or a setting has reached the audio side. A clear request empties the FIFO once that round trip completes. Four interrupt sources latch into sticky status bits. Each status bit is cleared by writing one to it, and each is masked onto a single interrupt line.

Top module: `audio_tx_fifo`

## Requirements
- R1: Out of reset, empty_o=1, full_o=0, can_accept_o=1, sync_o=1, err_o=0, int_stat_o=0 and irq_o=0. With 64 samples stored, full_o=1 and can_accept_o=0. full_o and empty_o are never high together.
- R2: needs_wr_o is selected by wr_thr_i. Code 0 asserts when the FIFO is empty. Codes 1 and 2 assert whenever at least one entry is free. Code 3 asserts only when exactly one entry is free (fill level 63).
- R3: dreq_o is high when dma_en_i=1 and the fill level is less than or equal to dreq_lvl_i. When dma_en_i=0, both dreq_o and panic_o are low.
- R4: panic_o is high when dma_en_i=1 and the fill level is less than or equal to panic_lvl_i.
- R5: Samples leave in the order they were written. The FIFO holds 64 samples, and a push while full is dropped.
- R6: A pop while the read side is empty returns pop_data_o=0 and sets err_o. err_o stays set until a cycle with err_clr_i=1.
- R7: A pulse on clr_req_i discards every stored sample. Pushes made in that cycle, and pushes made before sync_o returns high, are dropped. Once sync_o is high again, empty_o=1.
- R8: In the cycle after ctrl_wr_i or clr_req_i, sync_o is 0. It returns to 1 no sooner than two audio-clock periods later. A plain control write (ctrl_wr_i) keeps the stored samples.
- R9: Interrupt status bit 0 is needs-writing, bit 1 is rx_ready_i, bit 2 is the underflow event and bit 3 is rx_err_i. Each bit sets while its source is high and holds until one is written to the same bit of int_clr_i.
- R10: irq_o is high exactly when some status bit is set and its bit in irq_en_i is set. When irq_en_i=0, irq_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| aclk_i | input | 1 | Audio bit-clock domain clock |
| push_i | input | 1 | Write one sample |
| push_data_i | input | 32 | Sample to write |
| ctrl_wr_i | input | 1 | A control write occurred (restarts sync) |
| clr_req_i | input | 1 | Control write requesting FIFO clear |
| wr_thr_i | input | 2 | Needs-writing threshold select |
| dma_en_i | input | 1 | Enable DMA request and panic outputs |
| dreq_lvl_i | input | 7 | DMA request fill level |
| panic_lvl_i | input | 7 | Panic fill level |
| err_clr_i | input | 1 | Clear sticky underflow flag |
| rx_ready_i | input | 1 | Receive-ready interrupt source |
| rx_err_i | input | 1 | Receive-error interrupt source |
| irq_en_i | input | 4 | Interrupt enables |
| int_clr_i | input | 4 | Write-one-to-clear for status bits |
| full_o | output | 1 | FIFO full |
| empty_o | output | 1 | FIFO empty |
| can_accept_o | output | 1 | At least one free entry |
| needs_wr_o | output | 1 | Threshold-driven needs-writing flag |
| err_o | output | 1 | Sticky underflow flag |
| sync_o | output | 1 | Last control write has reached the audio side |
| dreq_o | output | 1 | DMA request |
| panic_o | output | 1 | DMA panic |
| int_stat_o | output | 4 | Sticky interrupt status |
| irq_o | output | 1 | Masked interrupt line |
| pop_i | input | 1 | Serializer pop, audio domain |
| pop_data_o | output | 32 | Head sample, or zero when empty |

## Verification
The assertions assume that software never issues a second control write while sync_o is low. Two writes in that window would flip the handshake toggle back and end the wait early. The stimulus therefore waits for sync_o after every control or clear pulse. The checks also assume that the serializer pops only on audio-clock edges, and that configuration inputs change on system-clock edges and stay still while the checked window runs. The bench changes configuration only at falling system edges. It enables popping only after the written samples have had several audio cycles to cross, so that any pop on an empty FIFO is a deliberate underflow.

// File: rtl/audio_tx_fifo_pkg.sv
`timescale 1ns/1ps
package audio_tx_fifo_pkg;
  typedef enum logic [1:0] {
    THR_EMPTY     = 2'd0,
    THR_ROOM_A    = 2'd1,
    THR_ROOM_B    = 2'd2,
    THR_LAST_SLOT = 2'd3
  } wr_thr_e;

  localparam int unsigned IRQ_N        = 4;
  localparam int unsigned IRQ_WR_NEED  = 0;
  localparam int unsigned IRQ_RD_READY = 1;
  localparam int unsigned IRQ_TX_ERR   = 2;
  localparam int unsigned IRQ_RX_ERR   = 3;
endpackage

// File: rtl/atf_sync.sv
`timescale 1ns/1ps
module atf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/atf_g2b.sv
`timescale 1ns/1ps
module atf_g2b #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] g_i,
  output logic [W-1:0] b_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_o[i] = ^g_i[W-1:i];
  end
endmodule

// File: rtl/atf_flags.sv
`timescale 1ns/1ps
module atf_flags
  import audio_tx_fifo_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned LW = AW + 1
) (
  input  logic [LW-1:0] level_i,
  input  logic [1:0]    thr_i,
  input  logic          dma_en_i,
  input  logic [LW-1:0] dreq_lvl_i,
  input  logic [LW-1:0] panic_lvl_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          can_accept_o,
  output logic          needs_wr_o,
  output logic          dreq_o,
  output logic          panic_o
);
  localparam logic [LW-1:0] DEPTH_L = LW'(1 << AW);
  localparam logic [LW-1:0] LAST_L  = LW'((1 << AW) - 1);

  always_comb begin
    empty_o      = (level_i == '0);
    full_o       = (level_i == DEPTH_L);
    can_accept_o = !full_o;
    unique case (wr_thr_e'(thr_i))
      THR_EMPTY:     needs_wr_o = empty_o;
      THR_ROOM_A,
      THR_ROOM_B:    needs_wr_o = can_accept_o;
      THR_LAST_SLOT: needs_wr_o = (level_i == LAST_L);
      default:       needs_wr_o = 1'b0;
    endcase
    dreq_o  = dma_en_i && (level_i <= dreq_lvl_i);
    panic_o = dma_en_i && (level_i <= panic_lvl_i);
  end
endmodule

// File: rtl/atf_rd_ctrl.sv
`timescale 1ns/1ps
module atf_rd_ctrl #(
  parameter int unsigned AW = 6
) (
  input  logic          aclk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic          req_tgl_s_i,
  input  logic          clr_pend_s_i,
  output logic [AW:0]   rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          empty_o,
  output logic          ack_tgl_o,
  output logic          ufl_tgl_o
);
  logic [AW:0] wbin_s, rbin_q, rbin_nx, rgray_q;
  logic        req_d_q, ufl_q, req_seen, do_clr;

  atf_g2b #(.W(AW + 1)) u_wg2b (.g_i(wgray_s_i), .b_o(wbin_s));

  assign req_seen = req_tgl_s_i ^ req_d_q;
  assign do_clr   = req_seen && clr_pend_s_i;
  assign empty_o  = (rbin_q == wbin_s);

  always_comb begin
    rbin_nx = rbin_q;
    if (do_clr)                rbin_nx = wbin_s;
    else if (pop_i && !empty_o) rbin_nx = rbin_q + 1'b1;
  end

  always_ff @(posedge aclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      req_d_q <= 1'b0;
      ufl_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      req_d_q <= req_tgl_s_i;
      if (pop_i && empty_o && !do_clr) ufl_q <= ~ufl_q;
    end
  end

  assign rgray_o   = rgray_q;
  assign raddr_o   = rbin_q[AW-1:0];
  assign ack_tgl_o = req_d_q;
  assign ufl_tgl_o = ufl_q;
endmodule

// File: rtl/atf_irq.sv
`timescale 1ns/1ps
module atf_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    // set wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[k] <= 1'b0;
      else         stat_q[k] <= (stat_q[k] && !clr_i[k]) || src_i[k];
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/audio_tx_fifo.sv
`timescale 1ns/1ps
module audio_tx_fifo
  import audio_tx_fifo_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 6,
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned LW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          aclk_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          ctrl_wr_i,
  input  logic          clr_req_i,
  input  logic [1:0]    wr_thr_i,
  input  logic          dma_en_i,
  input  logic [LW-1:0] dreq_lvl_i,
  input  logic [LW-1:0] panic_lvl_i,
  input  logic          err_clr_i,
  input  logic          rx_ready_i,
  input  logic          rx_err_i,
  input  logic [3:0]    irq_en_i,
  input  logic [3:0]    int_clr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          can_accept_o,
  output logic          needs_wr_o,
  output logic          err_o,
  output logic          sync_o,
  output logic          dreq_o,
  output logic          panic_o,
  output logic [3:0]    int_stat_o,
  output logic          irq_o,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  logic [AW:0]   wbin_q, wgray_q, rbin_s, rgray_s, rgray_a;
  logic [AW:0]   wgray_a;
  logic [LW-1:0] level;
  logic          req_tgl_q, clr_pend_q, busy, push_ok;
  logic [1:0]    ctl_a, back_a, back_s;
  logic          ufl_d_q, ufl_evt, err_q, rd_empty;
  logic [AW-1:0] raddr;
  logic [IRQ_N-1:0] irq_src;

  // system domain: write pointer, control toggle, error latch
  assign busy    = req_tgl_q ^ back_s[0];
  assign push_ok = push_i && !full_o && !clr_pend_q && !clr_req_i;
  assign ufl_evt = back_s[1] ^ ufl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      req_tgl_q  <= 1'b0;
      clr_pend_q <= 1'b0;
      ufl_d_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (push_ok) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= (wbin_q + 1'b1) ^ ((wbin_q + 1'b1) >> 1);
      end
      if (ctrl_wr_i || clr_req_i) begin
        req_tgl_q  <= ~req_tgl_q;
        clr_pend_q <= clr_req_i;
      end else if (!busy) begin
        clr_pend_q <= 1'b0;
      end
      ufl_d_q <= back_s[1];
      err_q   <= (err_q && !err_clr_i) || ufl_evt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wbin_q[AW-1:0]] <= push_data_i;
  end

  // crossings
  atf_sync #(.W(AW + 1), .STAGES(SYNC_N)) u_wptr_sync (
    .clk_i(aclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_a));
  atf_sync #(.W(2), .STAGES(SYNC_N)) u_ctl_sync (
    .clk_i(aclk_i), .rst_ni(rst_ni), .d_i({clr_pend_q, req_tgl_q}), .q_o(ctl_a));
  atf_sync #(.W(AW + 1), .STAGES(SYNC_N)) u_rptr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rgray_a), .q_o(rgray_s));
  atf_sync #(.W(2), .STAGES(SYNC_N)) u_back_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(back_a), .q_o(back_s));

  atf_g2b #(.W(AW + 1)) u_rg2b (.g_i(rgray_s), .b_o(rbin_s));

  // audio domain read side
  atf_rd_ctrl #(.AW(AW)) u_rd (
    .aclk_i      (aclk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop_i),
    .wgray_s_i   (wgray_a),
    .req_tgl_s_i (ctl_a[0]),
    .clr_pend_s_i(ctl_a[1]),
    .rgray_o     (rgray_a),
    .raddr_o     (raddr),
    .empty_o     (rd_empty),
    .ack_tgl_o   (back_a[0]),
    .ufl_tgl_o   (back_a[1])
  );

  assign pop_data_o = rd_empty ? '0 : mem_q[raddr];

  // status
  assign level = wbin_q - rbin_s;

  atf_flags #(.AW(AW), .LW(LW)) u_flags (
    .level_i     (level),
    .thr_i       (wr_thr_i),
    .dma_en_i    (dma_en_i),
    .dreq_lvl_i  (dreq_lvl_i),
    .panic_lvl_i (panic_lvl_i),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .can_accept_o(can_accept_o),
    .needs_wr_o  (needs_wr_o),
    .dreq_o      (dreq_o),
    .panic_o     (panic_o)
  );

  always_comb begin
    irq_src               = '0;
    irq_src[IRQ_WR_NEED]  = needs_wr_o;
    irq_src[IRQ_RD_READY] = rx_ready_i;
    irq_src[IRQ_TX_ERR]   = ufl_evt;
    irq_src[IRQ_RX_ERR]   = rx_err_i;
  end

  atf_irq #(.N(IRQ_N)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (irq_src),
    .en_i  (irq_en_i),
    .clr_i (int_clr_i),
    .stat_o(int_stat_o),
    .irq_o (irq_o)
  );

  assign err_o  = err_q;
  assign sync_o = !busy;
endmodule

// File: rtl/audio_tx_fifo_chk.sv
`timescale 1ns/1ps
module audio_tx_fifo_chk #(
  parameter int unsigned LW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          full_o,
  input logic          empty_o,
  input logic          can_accept_o,
  input logic          dma_en_i,
  input logic          dreq_o,
  input logic          panic_o,
  input logic [LW-1:0] dreq_lvl_i,
  input logic [LW-1:0] panic_lvl_i,
  input logic          err_o,
  input logic          err_clr_i,
  input logic          ctrl_wr_i,
  input logic          clr_req_i,
  input logic          sync_o,
  input logic          rx_ready_i,
  input logic [3:0]    int_stat_o,
  input logic [3:0]    int_clr_i,
  input logic [3:0]    irq_en_i,
  input logic          irq_o
);
  a_r1_not_full_and_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r1_full_blocks_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !can_accept_o);

  a_r3_dma_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> (!dreq_o && !panic_o));

  a_r4_panic_within_dreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (panic_o && (panic_lvl_i <= dreq_lvl_i)) |-> dreq_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  a_r8_sync_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i || clr_req_i) |=> !sync_o);

  a_r9_rx_rise_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_stat_o[1]) |-> $past(rx_ready_i));

  a_r9_stat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_stat_o[1] && !int_clr_i[1]) |=> int_stat_o[1]);

  a_r10_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 4'b0000) |-> !irq_o);
endmodule

bind audio_tx_fifo audio_tx_fifo_chk #(.LW(LW)) u_chk (.*);

// File: tb/audio_tx_fifo_bench.sv
`timescale 1ns/1ps
module audio_tx_fifo_bench;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int LW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam realtime ACLK_P = 37.0;

  logic clk = 1'b0, aclk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;
  always #(ACLK_P / 2.0) aclk = ~aclk;

  logic          push_i = 0, ctrl_wr_i = 0, clr_req_i = 0, dma_en_i = 0;
  logic [DW-1:0] push_data_i = '0;
  logic [1:0]    wr_thr_i = 2'd0;
  logic [LW-1:0] dreq_lvl_i = '0, panic_lvl_i = '0;
  logic          err_clr_i = 0, rx_ready_i = 0, rx_err_i = 0;
  logic [3:0]    irq_en_i = '0, int_clr_i = '0;
  logic          full_o, empty_o, can_accept_o, needs_wr_o, err_o, sync_o;
  logic          dreq_o, panic_o, irq_o, pop_i;
  logic [3:0]    int_stat_o;
  logic [DW-1:0] pop_data_o;
  logic          mon_pop = 0, ufl_pop = 0, drain_en = 0;

  assign pop_i = mon_pop | ufl_pop;

  audio_tx_fifo u_audio_tx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .aclk_i(aclk),
    .push_i(push_i), .push_data_i(push_data_i),
    .ctrl_wr_i(ctrl_wr_i), .clr_req_i(clr_req_i), .wr_thr_i(wr_thr_i),
    .dma_en_i(dma_en_i), .dreq_lvl_i(dreq_lvl_i), .panic_lvl_i(panic_lvl_i),
    .err_clr_i(err_clr_i), .rx_ready_i(rx_ready_i), .rx_err_i(rx_err_i),
    .irq_en_i(irq_en_i), .int_clr_i(int_clr_i),
    .full_o(full_o), .empty_o(empty_o), .can_accept_o(can_accept_o),
    .needs_wr_o(needs_wr_o), .err_o(err_o), .sync_o(sync_o),
    .dreq_o(dreq_o), .panic_o(panic_o), .int_stat_o(int_stat_o), .irq_o(irq_o),
    .pop_i(pop_i), .pop_data_o(pop_data_o)
  );

  int n_run = 0, n_fail = 0, seq = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic push_word(input logic [DW-1:0] d, input bit track);
    @(negedge clk);
    push_i = 1'b1;
    push_data_i = d;
    @(negedge clk);
    push_i = 1'b0;
    if (track) exp_q.push_back(d);
  endtask

  task automatic push_n(input int n, input bit track);
    for (int i = 0; i < n; i++) begin
      seq++;
      push_word(32'hA500_0000 + 32'(seq * 7), track);
    end
  endtask

  task automatic wait_aclk(input int n);
    repeat (n) @(negedge aclk);
  endtask

  task automatic drain();
    wait_aclk(10);
    drain_en = 1'b1;
    wait (exp_q.size() == 0);
    wait_aclk(2);
    drain_en = 1'b0;
    wait_aclk(6);
    @(negedge clk);
  endtask

  task automatic ctl_pulse(input bit clear);
    @(negedge clk);
    if (clear) clr_req_i = 1'b1; else ctrl_wr_i = 1'b1;
    @(negedge clk);
    clr_req_i = 1'b0;
    ctrl_wr_i = 1'b0;
  endtask

  // scoreboard monitor on the audio side
  always @(negedge aclk) begin
    if (drain_en && exp_q.size() > 0) begin
      chk("R5 data order", pop_data_o, exp_q[0]);
      void'(exp_q.pop_front());
      mon_pop = 1'b1;
    end else begin
      mon_pop = 1'b0;
    end
  end

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    realtime t0;
    #20;
    // R1 reset state
    chk("R1 empty at reset", 32'(empty_o), 1);
    chk("R1 full at reset", 32'(full_o), 0);
    chk("R1 accept at reset", 32'(can_accept_o), 1);
    chk("R1 sync at reset", 32'(sync_o), 1);
    chk("R1 err at reset", 32'(err_o), 0);
    chk("R1 stat at reset", 32'(int_stat_o), 0);
    chk("R1 irq at reset", 32'(irq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    dma_en_i = 1'b1;
    dreq_lvl_i = 7'd10;
    panic_lvl_i = 7'd3;

    // R3/R4 levels
    push_n(3, 1);
    chk("R3 dreq at level 3", 32'(dreq_o), 1);
    chk("R4 panic at level 3", 32'(panic_o), 1);
    push_n(1, 1);
    chk("R4 panic off at level 4", 32'(panic_o), 0);
    chk("R3 dreq at level 4", 32'(dreq_o), 1);
    push_n(6, 1);
    chk("R3 dreq at level 10", 32'(dreq_o), 1);
    push_n(1, 1);
    chk("R3 dreq off at level 11", 32'(dreq_o), 0);
    @(negedge clk);
    panic_lvl_i = 7'd20;
    dma_en_i = 1'b0;
    #1;
    chk("R3 dreq gated", 32'(dreq_o), 0);
    chk("R4 panic gated", 32'(panic_o), 0);
    dma_en_i = 1'b1;
    #1;
    chk("R4 panic at level 11 below 20", 32'(panic_o), 1);

    // R2 thresholds
    wr_thr_i = 2'd0; #1;
    chk("R2 code0 not empty", 32'(needs_wr_o), 0);
    wr_thr_i = 2'd1; #1;
    chk("R2 code1 room", 32'(needs_wr_o), 1);
    wr_thr_i = 2'd2; #1;
    chk("R2 code2 room", 32'(needs_wr_o), 1);
    wr_thr_i = 2'd3;
    push_n(62 - 11, 1);
    chk("R2 code3 at 62", 32'(needs_wr_o), 0);
    push_n(1, 1);
    chk("R2 code3 at 63", 32'(needs_wr_o), 1);
    push_n(1, 1);
    chk("R1 full at 64", 32'(full_o), 1);
    chk("R1 no accept at 64", 32'(can_accept_o), 0);
    chk("R2 code3 at 64", 32'(needs_wr_o), 0);
    chk("R1 not empty at 64", 32'(empty_o), 0);
    wr_thr_i = 2'd1; #1;
    chk("R2 code1 full", 32'(needs_wr_o), 0);
    push_word(32'hDEAD_BEEF, 0);
    chk("R5 full after extra push", 32'(full_o), 1);

    // R5 drain, extra push must not appear
    drain();
    chk("R5 empty after 64 pops", 32'(empty_o), 1);
    chk("R1 accept after drain", 32'(can_accept_o), 1);
    wr_thr_i = 2'd0; #1;
    chk("R2 code0 empty", 32'(needs_wr_o), 1);

    // R6 underflow
    @(negedge aclk);
    chk("R6 zero on empty pop", pop_data_o, 0);
    ufl_pop = 1'b1;
    @(negedge aclk);
    ufl_pop = 1'b0;
    wait_aclk(3);
    @(negedge clk);
    chk("R6 err set", 32'(err_o), 1);
    chk("R9 tx err status", 32'(int_stat_o[2]), 1);
    repeat (5) @(negedge clk);
    chk("R6 err sticky", 32'(err_o), 1);
    err_clr_i = 1'b1;
    int_clr_i = 4'b0100;
    @(negedge clk);
    err_clr_i = 1'b0;
    int_clr_i = 4'b0000;
    chk("R6 err cleared", 32'(err_o), 0);
    chk("R9 tx err w1c", 32'(int_stat_o[2]), 0);

    // R7/R8 clear
    push_n(5, 0);
    wait_aclk(10);
    @(negedge clk);
    chk("R7 holds data before clear", 32'(empty_o), 0);
    t0 = $realtime;
    ctl_pulse(1);
    chk("R8 sync low after clear", 32'(sync_o), 0);
    push_word(32'hBAD0_0001, 0);
    wait (sync_o);
    chk("R8 two audio clocks", 32'(($realtime - t0) >= 2.0 * ACLK_P), 1);
    @(negedge clk);
    chk("R7 empty after clear", 32'(empty_o), 1);
    push_n(2, 1);
    drain();
    chk("R7 only new samples", 32'(empty_o), 1);

    // R8 plain control write keeps data
    push_n(2, 1);
    wait_aclk(6);
    ctl_pulse(0);
    chk("R8 sync low after write", 32'(sync_o), 0);
    wait (sync_o);
    @(negedge clk);
    chk("R8 data kept", 32'(empty_o), 0);
    drain();

    // R9/R10 interrupts
    @(negedge clk);
    irq_en_i = 4'b0010;
    rx_ready_i = 1'b1;
    @(negedge clk);
    rx_ready_i = 1'b0;
    chk("R9 rx ready latched", 32'(int_stat_o[1]), 1);
    chk("R10 irq enabled", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    chk("R9 rx ready sticky", 32'(int_stat_o[1]), 1);
    int_clr_i = 4'b0010;
    @(negedge clk);
    int_clr_i = 4'b0000;
    chk("R9 rx ready w1c", 32'(int_stat_o[1]), 0);
    chk("R10 irq drops", 32'(irq_o), 0);
    irq_en_i = 4'b0000;
    rx_err_i = 1'b1;
    @(negedge clk);
    rx_err_i = 1'b0;
    chk("R9 rx err latched", 32'(int_stat_o[3]), 1);
    chk("R10 irq masked", 32'(irq_o), 0);
    irq_en_i = 4'b1000; #1;
    chk("R10 irq unmasked", 32'(irq_o), 1);

    finish_run();
  end
endmodule